// File: doc/BRIEF.md
# Monitor Capture and Playback Buffer

This block sits between two processing stages of a per-channel data path and keeps a circular record, one word per crossing tick, of what enters the downstream stage. It is built on a fully synchronous dual-port memory. One port runs at tick rate and is addressed by a counter that is cleared by a turn-start marker. The other port belongs to a host, which can read or write any word at any time.

In monitor mode the live word is written to memory and clocked into the downstream stage on the same enabled edge. In playback mode, writes from the tick side are blocked and the stage takes its value from memory instead. The memory read has one clock of latency, so the replayed word reaches the stage one tick after its address was used. As a result, the simulation word for a crossing must sit one address below the place where that crossing's monitor word would be captured. A freeze input stops capture so that the host can read a stable snapshot. While frozen, the data path still passes live words to the stage.

Top module: `mon_play_buf`

## Requirements
- R1: After reset, `data_o` and `host_rdata_o` are zero, and the first tick that arrives without a turn-start marker uses address 0.
- R2: A tick with `turn_start_i` high uses address 0. Every other tick uses the previous tick's address plus one, wrapping modulo 2^ADDR_W. Without a tick, the address and `data_o` hold.
- R3: On a tick with `play_mode_i`=0 (monitor) and `freeze_i`=0, `live_i` is written into memory at that tick's address.
- R4: On a tick in monitor mode, `data_o` takes `live_i` on the same edge that performs the write.
- R5: On a tick with `play_mode_i`=1, `data_o` takes the word read at the previous tick. The word at address A-1 therefore appears after the tick that uses address A.
- R6: In playback mode, ticks write nothing to memory.
- R7: While `freeze_i`=1, ticks write nothing to memory, and in monitor mode `data_o` still follows `live_i`.
- R8: `host_rdata_o` shows, one clock after an edge, the word at `host_addr_i` as it was before any write on that edge.
- R9: `host_we_i`=1 writes `host_wdata_i` at `host_addr_i` on any clock edge, with or without a tick.
- R10: If a host write and a tick write hit the same address on the same edge, the tick's word is kept.
- R11: Host reads and writes never delay or alter the tick-side read or `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Crossing tick enable |
| turn_start_i | input | 1 | Turn-start marker; the current tick uses address 0 |
| play_mode_i | input | 1 | 0 = monitor, 1 = playback |
| freeze_i | input | 1 | Save-monitor request; blocks capture |
| live_i | input | DATA_W | Live word from the upstream stage |
| data_o | output | DATA_W | Word to the downstream stage |
| host_addr_i | input | ADDR_W | Host address |
| host_wdata_i | input | DATA_W | Host write data |
| host_we_i | input | 1 | Host write strobe |
| host_rdata_o | output | DATA_W | Host read data, one clock of latency |

## Verification
A tick-side capture and a host access can land on the same edge. The bench provokes this twice. First, a host write and a monitor tick both target address 0 on one edge; the later read-back must return the tick's word. Second, a host read is issued on the very edge where a tick overwrites that address; the read must return the host-written word that was there before the tick. During the full playback sweep, the host also reads every address on the same cycles that the tick port replays them, and both outputs are compared with the arithmetic patterns on each cycle.

// File: rtl/mon_buf_pkg.sv
package mon_buf_pkg;
  typedef enum logic {
    MODE_MONITOR = 1'b0,
    MODE_PLAY    = 1'b1
  } buf_mode_e;
endpackage

// File: rtl/mpb_tick_ctr.sv
module mpb_tick_ctr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              turn_start_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q;

  assign addr_o = turn_start_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= addr_o + ADDR_W'(1);
  end

  a_r2_turn_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && turn_start_i |=> cnt_q == ADDR_W'(1));
  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/mpb_dp_ram.sv
module mpb_dp_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              a_wr;

  assign a_wr = a_en_i && a_we_i;

  // tick port written last: it wins a same-address collision
  always_ff @(posedge clk_i) begin
    if (b_we_i) mem[b_addr_i] <= b_wdata_i;
    if (a_wr)   mem[a_addr_i] <= a_wdata_i;
  end

  // read-before-write on both ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_en_i) a_rdata_o <= mem[a_addr_i];
      b_rdata_o <= mem[b_addr_i];
    end
  end

  a_r10_tick_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_wr && b_we_i && (a_addr_i == b_addr_i) |=> mem[$past(a_addr_i)] == $past(a_wdata_i));
  a_r9_host_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_we_i && !(a_wr && (a_addr_i == b_addr_i)) |=> mem[$past(b_addr_i)] == $past(b_wdata_i));
  a_r11_tick_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_en_i |=> $stable(a_rdata_o));
endmodule

// File: rtl/mpb_stage.sv
module mpb_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              play_i,
  input  logic [DATA_W-1:0] live_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (tick_i) data_o <= play_i ? mem_i : live_i;
  end

  a_r4_pass_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !play_i |=> data_o == $past(live_i));
  a_r5_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && play_i |=> data_o == $past(mem_i));
  a_r2_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(data_o));
endmodule

// File: rtl/mon_play_buf.sv
module mon_play_buf
  import mon_buf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              turn_start_i,
  input  logic              play_mode_i,
  input  logic              freeze_i,
  input  logic [DATA_W-1:0] live_i,
  output logic [DATA_W-1:0] data_o,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_we_i,
  output logic [DATA_W-1:0] host_rdata_o
);
  buf_mode_e         mode;
  logic              play;
  logic              cap_we;
  logic [ADDR_W-1:0] tick_addr;
  logic [DATA_W-1:0] tick_rdata;

  assign mode   = buf_mode_e'(play_mode_i);
  assign play   = (mode == MODE_PLAY);
  assign cap_we = !play && !freeze_i;

  mpb_tick_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_en_i),
    .turn_start_i (turn_start_i),
    .addr_o       (tick_addr)
  );

  mpb_dp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_en_i    (tick_en_i),
    .a_we_i    (cap_we),
    .a_addr_i  (tick_addr),
    .a_wdata_i (live_i),
    .a_rdata_o (tick_rdata),
    .b_we_i    (host_we_i),
    .b_addr_i  (host_addr_i),
    .b_wdata_i (host_wdata_i),
    .b_rdata_o (host_rdata_o)
  );

  mpb_stage #(.DATA_W(DATA_W)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_en_i),
    .play_i (play),
    .live_i (live_i),
    .mem_i  (tick_rdata),
    .data_o (data_o)
  );

  a_r7_freeze_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i && freeze_i && !play_mode_i |=> data_o == $past(live_i));
  a_r11_host_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i && play_mode_i |=> data_o == $past(tick_rdata));
endmodule

// File: tb/tb_mon_play_buf.sv
module tb_mon_play_buf;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0, turn_start = 1'b0, play = 1'b0, freeze = 1'b0;
  logic [DW-1:0] live = '0;
  logic [DW-1:0] data_o;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_we = 1'b0;
  logic [DW-1:0] host_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mon_play_buf #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .turn_start_i(turn_start),
    .play_mode_i(play), .freeze_i(freeze), .live_i(live), .data_o(data_o),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_we_i(host_we),
    .host_rdata_o(host_rdata)
  );

  function automatic logic [DW-1:0] f_mon(int i);  return DW'(i * 7 + 3) ^ 8'h5A; endfunction
  function automatic logic [DW-1:0] f_sim(int a);  return DW'(a * 13 + 1);        endfunction
  function automatic logic [DW-1:0] f_frz(int i);  return DW'(i + 200);           endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(logic ts, logic [DW-1:0] v);
    tick_en = 1'b1; turn_start = ts; live = v;
    @(posedge clk); #1;
    tick_en = 1'b0; turn_start = 1'b0;
  endtask

  task automatic hread(logic [AW-1:0] a, output logic [DW-1:0] d);
    host_addr = a;
    @(posedge clk); #1;
    d = host_rdata;
  endtask

  task automatic hwrite(logic [AW-1:0] a, logic [DW-1:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 data_o reset", data_o, '0);
    chk("R1 host_rdata reset", host_rdata, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: first tick without marker lands at address 0
    tick(1'b0, 8'h77);
    hread(0, rd); chk("R1 first tick addr0", rd, 8'h77);

    // R3/R4: monitor sweep over all addresses
    for (int i = 0; i < N; i++) begin
      tick(i == 0, f_mon(i));
      chk("R4 monitor pass-through", data_o, f_mon(i));
    end
    for (int a = 0; a < N; a++) begin
      hread(AW'(a), rd); chk("R3 capture at tick address", rd, f_mon(a));
    end

    // R2: wrap to address 0, then hold without ticks
    tick(1'b0, 8'hC3);
    for (int k = 0; k < 3; k++) begin
      live = DW'(k + 1);
      @(posedge clk); #1;
      chk("R2 hold without tick", data_o, 8'hC3);
    end
    hread(0, rd); chk("R2 wrap to address 0", rd, 8'hC3);
    hread(1, rd); chk("R2 no write without tick", rd, f_mon(1));

    // R7: freeze blocks capture, pass-through continues
    freeze = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(i == 0, f_frz(i));
      chk("R7 freeze pass-through", data_o, f_frz(i));
    end
    freeze = 1'b0;
    hread(0, rd); chk("R7 freeze keeps addr0", rd, 8'hC3);
    for (int a = 1; a < 4; a++) begin
      hread(AW'(a), rd); chk("R7 freeze keeps snapshot", rd, f_mon(a));
    end

    // R9: host loads simulation words at every address
    for (int a = 0; a < N; a++) hwrite(AW'(a), f_sim(a));
    for (int a = 0; a < N; a++) begin
      hread(AW'(a), rd); chk("R9 host write read-back", rd, f_sim(a));
    end

    // R5/R11: playback sweep with concurrent host reads
    play = 1'b1;
    for (int k = 0; k < N; k++) begin
      host_addr = AW'(k);
      tick(k == 0, 8'hEE);
      if (k > 0) chk("R5 replay from address A-1", data_o, f_sim(k - 1));
      chk("R11 host read during replay", host_rdata, f_sim(k));
    end
    tick(1'b0, 8'hEE);
    chk("R5 replay after wrap", data_o, f_sim(N - 1));
    play = 1'b0;
    for (int a = 0; a < N; a++) begin
      hread(AW'(a), rd); chk("R6 playback writes nothing", rd, f_sim(a));
    end

    // R10: host write and tick write on the same address and edge
    tick_en = 1'b1; turn_start = 1'b1; live = 8'hAA;
    host_addr = 0; host_wdata = 8'h55; host_we = 1'b1;
    @(posedge clk); #1;
    host_we = 1'b0; turn_start = 1'b0;
    // R8: host read on the edge that overwrites address 1
    live = 8'hBB; host_addr = 1;
    @(posedge clk); #1;
    tick_en = 1'b0;
    chk("R8 read returns pre-write word", host_rdata, f_sim(1));
    hread(1, rd); chk("R8 later read sees tick word", rd, 8'hBB);
    hread(0, rd); chk("R10 tick wins collision", rd, 8'hAA);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule